// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache

This block is a direct-mapped cache that sits between one processor and a shared snooping bus. It keeps its copies coherent with peer caches through a two-state protocol. Each line is either valid or invalid. A line that is not present counts as invalid. Reads that hit are answered from the local copy. Reads that miss fetch the word over the bus and fill the line. Every processor write goes to the bus as a write-through, and it updates the local copy only if that copy is valid. A write that misses does not allocate a line.

The cache also watches a snoop input, which carries the addresses of writes made by other bus agents. When one of those addresses matches a valid line, that line is dropped, so the next local read fetches the new value. Any number of caches may hold the same word valid at the same time for reading. A processor access is held until the bus has granted and finished its transaction. The processor therefore sees a write retire only after the memory side has taken it.

Top module: `wti_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ack` and `bus_req` are low, and the first read of any address goes to the bus.
- R2: A read whose word is held valid is acknowledged in the same cycle it is presented, with the cached word on `cpu_rdata` and no bus request.
- R3: A read that misses raises `bus_req` with `bus_we` low and `bus_addr` equal to the request address. On completion the word read from the bus fills the line and makes it valid, replacing any other tag at that index. A later read of the same address then hits.
- R4: Every processor write raises `bus_req` with `bus_we` high, `bus_addr` equal to the request address and `bus_wdata` equal to the write data. If the line was valid, the cached word takes the new value.
- R5: A write that misses leaves the line invalid (no allocation), so a following read of that address goes to the bus.
- R6: A snoop whose full address matches a valid line makes that line invalid, including when it arrives in the first cycle of a local write to that address.
- R7: A snoop whose address matches no valid line has no effect: a snoop to another index, or to the same index with a different tag, leaves the held word readable as a hit.
- R8: When a snoop to an address arrives in the same cycle as a read hit on that address, the snoop wins. The read is handled as a miss and goes to the bus.
- R9: For any access that uses the bus, `cpu_ack` rises exactly one cycle after the cycle in which `bus_done` is sampled high. For reads, `cpu_rdata` then equals the `bus_rdata` value of that cycle. `cpu_ack` is a single-cycle pulse.
- R10: When a snoop matches the address of a pending bus read, the read still returns the fetched word to the processor, but the line is not left valid.
- R11: Once raised, `bus_req` stays high with `bus_addr` and `bus_we` unchanged until `bus_gnt` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor access request; held with its fields until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; the low log2(LINES) bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` on reads |
| bus_req | output | 1 | Bus request, held until granted |
| bus_we | output | 1 | Bus transaction kind, 1 = write |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_gnt | input | 1 | Grant; the transaction starts in the cycle after it |
| bus_done | input | 1 | Transaction complete |
| bus_rdata | input | DATA_W | Read data, sampled with `bus_done` |
| snp_valid | input | 1 | Another agent's bus write is visible this cycle |
| snp_addr | input | ADDR_W | Word address of that write |

## Verification
Two events can land in the same cycle: a snoop invalidation and a local access to the same word. The bench provokes this by presenting a snoop together with a read that would otherwise hit. It then checks that no acknowledgement comes in that cycle and that a bus read follows. It does the same with a write, and checks that the next read misses. A third case raises the snoop while a read is still waiting for its grant. Here the returned word must reach the processor, and the following read of the same address must go back to the bus.

// File: rtl/wti_pkg.sv
package wti_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2,
      ST_RESP = 2'd3
   } wti_state_e;
endpackage

// File: rtl/wti_tag_store.sv
module wti_tag_store #(
   parameter int LINES = 16,
   parameter int IDX_W = 4,
   parameter int TAG_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   input  logic             snp_en,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag
);
   logic [LINES-1:0] valid_w;
   logic [TAG_W-1:0] tag_w [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      logic             kill;
      logic             load;

      // a snoop only removes a line whose stored tag equals the snooped tag
      assign kill = snp_en && (snp_idx == IDX_W'(g)) && v_q && (t_q == snp_tag);
      assign load = fill_en && (fill_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
         end else if (load) begin
            v_q <= 1'b1;
            t_q <= fill_tag;
         end else if (kill) begin
            v_q <= 1'b0;
         end
      end

      assign valid_w[g] = v_q;
      assign tag_w[g]   = t_q;

      // R6: a matching snoop leaves the line invalid in the next cycle
      a_r6_snoop_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
         (snp_en && snp_idx == IDX_W'(g) && valid_w[g] && tag_w[g] == snp_tag && !load)
         |=> !valid_w[g]);
   end

   assign lk_hit = valid_w[lk_idx] && (tag_w[lk_idx] == lk_tag);
endmodule

// File: rtl/wti_data_store.sv
module wti_data_store #(
   parameter int LINES  = 16,
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] word_w [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_word
      logic [DATA_W-1:0] w_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 w_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))      w_q <= wr_data;
      end
      assign word_w[g] = w_q;
   end

   assign rd_data = word_w[rd_idx];
endmodule

// File: rtl/wti_ctrl.sv
module wti_ctrl
   import wti_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_req,
   input  logic cpu_we,
   input  logic lk_hit,
   input  logic snp_cur,
   input  logic snp_pend,
   input  logic req_we,
   input  logic bus_gnt,
   input  logic bus_done,
   output logic busy,
   output logic start,
   output logic cpu_ack,
   output logic resp_sel,
   output logic bus_req,
   output logic fill_en,
   output logic data_we,
   output logic rd_cap
);
   wti_state_e state_q, state_d;
   logic       poison_q;

   always_comb begin
      state_d  = state_q;
      start    = 1'b0;
      cpu_ack  = 1'b0;
      resp_sel = 1'b0;
      bus_req  = 1'b0;
      fill_en  = 1'b0;
      data_we  = 1'b0;
      rd_cap   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cpu_req) begin
               if (!cpu_we && lk_hit && !snp_cur) begin
                  cpu_ack = 1'b1;
               end else begin
                  start   = 1'b1;
                  state_d = ST_REQ;
               end
            end
         end
         ST_REQ: begin
            bus_req = 1'b1;
            if (bus_gnt) state_d = ST_XFER;
         end
         ST_XFER: begin
            if (bus_done) begin
               state_d = ST_RESP;
               rd_cap  = !req_we;
               fill_en = !req_we && !poison_q && !snp_pend;
               data_we = req_we ? lk_hit : fill_en;
            end
         end
         ST_RESP: begin
            cpu_ack  = 1'b1;
            resp_sel = 1'b1;
            state_d  = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         poison_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start)
            poison_q <= 1'b0;
         else if ((state_q == ST_REQ || state_q == ST_XFER) && snp_pend)
            poison_q <= 1'b1;
      end
   end

   assign busy = (state_q != ST_IDLE);

   // R9: completion reaches the processor one cycle after the bus finishes
   a_r9_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_XFER && bus_done) |=> cpu_ack);
   // R11: a raised request is not withdrawn before the grant
   a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> bus_req);
   // R8: a same-cycle snoop on the requested word denies the local hit
   a_r8_snoop_beats_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cpu_req && !cpu_we && snp_cur) |-> !cpu_ack);
   // R10: a snooped pending read never installs its line
   a_r10_no_poisoned_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (poison_q && state_q == ST_XFER) |-> !fill_en);
endmodule

// File: rtl/wti_cache.sv
module wti_cache #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int LINES  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic              bus_done,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("wti_cache: LINES must be a power of two, at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("wti_cache: ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("wti_cache: DATA_W must be positive");
   end

   logic [ADDR_W-1:0] req_addr_q;
   logic              req_we_q;
   logic [DATA_W-1:0] req_wd_q;
   logic [DATA_W-1:0] rd_q;

   logic              busy, start, resp_sel, fill_en, data_we, rd_cap, lk_hit;
   logic              snp_cur, snp_pend;
   logic [ADDR_W-1:0] lk_addr;
   logic [DATA_W-1:0] line_word;

   assign lk_addr  = busy ? req_addr_q : cpu_addr;
   assign snp_cur  = snp_valid && (snp_addr == cpu_addr);
   assign snp_pend = snp_valid && (snp_addr == req_addr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_addr_q <= '0;
         req_we_q   <= 1'b0;
         req_wd_q   <= '0;
         rd_q       <= '0;
      end else begin
         if (start) begin
            req_addr_q <= cpu_addr;
            req_we_q   <= cpu_we;
            req_wd_q   <= cpu_wdata;
         end
         if (rd_cap) rd_q <= bus_rdata;
      end
   end

   wti_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_req  (cpu_req),
      .cpu_we   (cpu_we),
      .lk_hit   (lk_hit),
      .snp_cur  (snp_cur),
      .snp_pend (snp_pend),
      .req_we   (req_we_q),
      .bus_gnt  (bus_gnt),
      .bus_done (bus_done),
      .busy     (busy),
      .start    (start),
      .cpu_ack  (cpu_ack),
      .resp_sel (resp_sel),
      .bus_req  (bus_req),
      .fill_en  (fill_en),
      .data_we  (data_we),
      .rd_cap   (rd_cap)
   );

   wti_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (lk_addr[IDX_W-1:0]),
      .lk_tag   (lk_addr[ADDR_W-1:IDX_W]),
      .lk_hit   (lk_hit),
      .snp_en   (snp_valid),
      .snp_idx  (snp_addr[IDX_W-1:0]),
      .snp_tag  (snp_addr[ADDR_W-1:IDX_W]),
      .fill_en  (fill_en),
      .fill_idx (req_addr_q[IDX_W-1:0]),
      .fill_tag (req_addr_q[ADDR_W-1:IDX_W])
   );

   wti_data_store #(.LINES(LINES), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (data_we),
      .wr_idx  (req_addr_q[IDX_W-1:0]),
      .wr_data (req_we_q ? req_wd_q : bus_rdata),
      .rd_idx  (lk_addr[IDX_W-1:0]),
      .rd_data (line_word)
   );

   assign cpu_rdata = resp_sel ? rd_q : line_word;
   assign bus_we    = req_we_q;
   assign bus_addr  = req_addr_q;
   assign bus_wdata = req_wd_q;

   // R11: address and kind are steady while the request waits for a grant
   a_r11_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> ($stable(bus_addr) && $stable(bus_we)));
   // R4: a write is acknowledged only after a bus completion
   a_r4_write_retires_late: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_we) |-> $past(bus_done));
   // R9: the acknowledgement is a single-cycle pulse
   a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && busy) |=> !cpu_ack);
endmodule

// File: tb/wti_cache_test.sv
module wti_cache_test;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SN = 2'd2;

   typedef struct packed {
      logic [1:0]    op;
      logic [AW-1:0] addr;
      logic [DW-1:0] wd;
      logic [DW-1:0] bd;
      logic          xbus;
      logic [DW-1:0] xrd;
      logic [1:0]    snp;   // 0 none, 1 with the request, 2 with the grant
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{OP_RD, 16'h0013, 32'h0,          32'h11110013, 1'b1, 32'h11110013, 2'd0, 4'd3},  // R3 cold miss
      '{OP_RD, 16'h0013, 32'h0,          32'h0,        1'b0, 32'h11110013, 2'd0, 4'd2},  // R2 hit
      '{OP_WR, 16'h0013, 32'h22220013,   32'h0,        1'b1, 32'h0,        2'd0, 4'd4},  // R4 write hit
      '{OP_RD, 16'h0013, 32'h0,          32'h0,        1'b0, 32'h22220013, 2'd0, 4'd4},  // R4 copy updated
      '{OP_WR, 16'h0025, 32'h33330025,   32'h0,        1'b1, 32'h0,        2'd0, 4'd5},  // R5 write miss
      '{OP_RD, 16'h0025, 32'h0,          32'h44440025, 1'b1, 32'h44440025, 2'd0, 4'd5},  // R5 no allocate
      '{OP_SN, 16'h0013, 32'h0,          32'h0,        1'b0, 32'h0,        2'd0, 4'd6},  // R6 snoop
      '{OP_RD, 16'h0013, 32'h0,          32'h55550013, 1'b1, 32'h55550013, 2'd0, 4'd6},  // R6 now miss
      '{OP_SN, 16'h0113, 32'h0,          32'h0,        1'b0, 32'h0,        2'd0, 4'd7},  // R7 other tag
      '{OP_RD, 16'h0013, 32'h0,          32'h0,        1'b0, 32'h55550013, 2'd0, 4'd7},  // R7 still hit
      '{OP_SN, 16'h0014, 32'h0,          32'h0,        1'b0, 32'h0,        2'd0, 4'd7},  // R7 other index
      '{OP_RD, 16'h0025, 32'h0,          32'h0,        1'b0, 32'h44440025, 2'd0, 4'd7},  // R7 still hit
      '{OP_RD, 16'h0025, 32'h0,          32'h66660025, 1'b1, 32'h66660025, 2'd1, 4'd8},  // R8 snoop wins
      '{OP_RD, 16'h0025, 32'h0,          32'h0,        1'b0, 32'h66660025, 2'd0, 4'd3},  // R3 refilled
      '{OP_RD, 16'h0113, 32'h0,          32'h77770113, 1'b1, 32'h77770113, 2'd0, 4'd3},  // R3 conflict fill
      '{OP_RD, 16'h0013, 32'h0,          32'h88880013, 1'b1, 32'h88880013, 2'd0, 4'd3},  // R3 evicted
      '{OP_WR, 16'h0013, 32'h99990013,   32'h0,        1'b1, 32'h0,        2'd1, 4'd6},  // R6 snoop with write
      '{OP_RD, 16'h0013, 32'h0,          32'hAAAA0013, 1'b1, 32'hAAAA0013, 2'd0, 4'd6},  // R6 line gone
      '{OP_RD, 16'h0037, 32'h0,          32'hBBBB0037, 1'b1, 32'hBBBB0037, 2'd2, 4'd10}, // R10 pending snoop
      '{OP_RD, 16'h0037, 32'h0,          32'hCCCC0037, 1'b1, 32'hCCCC0037, 2'd0, 4'd10}, // R10 not kept
      '{OP_RD, 16'h0037, 32'h0,          32'h0,        1'b0, 32'hCCCC0037, 2'd0, 4'd3}   // R3 hit after fill
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ack;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req, bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_gnt = 1'b0, bus_done = 1'b0;
   logic [DW-1:0] bus_rdata = '0;
   logic          snp_valid = 1'b0;
   logic [AW-1:0] snp_addr = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   wti_cache uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
      .snp_valid(snp_valid), .snp_addr(snp_addr)
   );

   task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic run_op(input vec_t v, output logic acked, output logic used,
                         output logic [DW-1:0] got, output logic bwe,
                         output logic [AW-1:0] ba, output logic [DW-1:0] bwd,
                         output logic gap_ok);
      int waitc = 0;
      int bph = 0;
      int done_t = -10;
      acked = 0; used = 0; got = '0; bwe = 0; ba = '0; bwd = '0; gap_ok = 1;
      @(negedge clk);
      if (v.op == OP_SN) begin
         snp_valid = 1'b1; snp_addr = v.addr;
         @(negedge clk);
         snp_valid = 1'b0;
         return;
      end
      cpu_req = 1'b1; cpu_we = (v.op == OP_WR); cpu_addr = v.addr; cpu_wdata = v.wd;
      if (v.snp == 2'd1) begin snp_valid = 1'b1; snp_addr = v.addr; end
      for (int t = 0; t < 40; t++) begin
         #1;
         if (cpu_ack) begin
            acked = 1; got = cpu_rdata;
            gap_ok = !used || (t == done_t + 1);
            break;
         end
         if (bus_req && bph == 0) begin
            if (!used) begin used = 1; bwe = bus_we; ba = bus_addr; bwd = bus_wdata; end
            waitc++;
            if (waitc == 2) begin
               bus_gnt = 1'b1; bph = 1;
               if (v.snp == 2'd2) begin snp_valid = 1'b1; snp_addr = v.addr; end
            end
         end else if (bph == 1) begin
            bus_done = 1'b1; bus_rdata = v.bd; bph = 2; done_t = t;
         end
         @(negedge clk);
         bus_gnt = 1'b0; bus_done = 1'b0; snp_valid = 1'b0;
      end
      @(negedge clk);
      cpu_req = 1'b0; snp_valid = 1'b0; bus_gnt = 1'b0; bus_done = 1'b0;
   endtask

   task automatic apply(input vec_t v);
      logic acked, used, bwe, gap_ok;
      logic [DW-1:0] got, bwd;
      logic [AW-1:0] ba;
      string tag;
      run_op(v, acked, used, got, bwe, ba, bwd, gap_ok);
      if (v.op == OP_SN) return;
      tag = $sformatf("R%0d addr %h", v.req, v.addr);
      check(acked == 1'b1, {tag, " ack seen"}, DW'(acked), 1);
      check(used == v.xbus, {tag, " bus used"}, DW'(used), DW'(v.xbus));
      if (v.op == OP_RD)
         check(got == v.xrd, {tag, " read data"}, got, v.xrd);
      if (used) begin
         check(ba == v.addr, {tag, " R4 bus address"}, DW'(ba), DW'(v.addr));
         check(bwe == (v.op == OP_WR), {tag, " R3 bus kind"}, DW'(bwe), DW'(v.op == OP_WR));
         if (v.op == OP_WR)
            check(bwd == v.wd, {tag, " R4 bus write data"}, bwd, v.wd);
         check(gap_ok, {tag, " R9 ack one cycle after done"}, DW'(gap_ok), 1);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1: quiet outputs while in reset
      check(!cpu_ack && !bus_req, "R1 reset outputs", DW'({cpu_ack, bus_req}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) apply(VEC[i]);

      // R1: reset empties the cache, so a previously hit address misses
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(!cpu_ack && !bus_req, "R1 outputs in second reset", DW'({cpu_ack, bus_req}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      apply('{OP_RD, 16'h0037, 32'h0, 32'hDDDD0037, 1'b1, 32'hDDDD0037, 2'd0, 4'd1}); // R1 miss after reset
      apply('{OP_RD, 16'h0113, 32'h0, 32'hEEEE0113, 1'b1, 32'hEEEE0113, 2'd0, 4'd1}); // R1 miss after reset

      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule